// File: doc/BRIEF.md
# Converter Conversion and Power-State Sequencer

This block is the control machine of a successive-approximation converter. A rising edge on the conversion-start input begins one conversion. An active-low busy flag is held low for a fixed number of system clock cycles. Any further start edges that arrive while the conversion runs have no effect. When the conversion finishes, a result-valid flag is raised, unless it is the first conversion after leaving deep power-down.

Two low-power states are driven by two configuration bits that the serial interface has already latched. The serial interface also supplies a strobe for each falling serial-clock edge, together with the 1-based index of that edge within the current frame. A light power-down state is entered as the conversion ends and is left at an early clock edge of the next frame. A deep power-down state is entered at the last clock edge of a frame. To leave deep power-down, a start edge arms the exit, and a later frame that clears the deep bit completes it at its last edge. The block then waits a fixed settling delay before it accepts new start edges. The power state is reported both as a code and as two enables.

Top module: `adc_power_sequencer`

## Requirements
- R1: On the first clock edge where `convSt` is seen high after being low, with the block in state ON (code 0), idle and not settling, `busyN` goes low from that edge on.
- R2: `busyN` stays low for exactly `CONV_CYCLES` clock cycles per conversion and then returns high.
- R3: Start edges during a conversion are ignored. The busy period keeps its length and no second conversion follows it.
- R4: Only edges start conversions. A `convSt` held high past the end of a conversion does not start another one.
- R5: When a conversion ends with `cfgNap`=1 and `cfgSleep`=0, `powerState` becomes 1 (light power-down) and `napEn` goes high at the edge where `busyN` rises. Start edges in this state are ignored.
- R6: Light power-down ends, and `powerState` returns to 0, at the `sckFall` strobe whose `sckIndex` equals `NAP_EXIT_EDGE` (2). Earlier edges leave the state unchanged.
- R7: `cfgSleep`=1 takes priority over `cfgNap`. A conversion that ends with both bits set leaves the state at 0. The `sckFall` strobe with `sckIndex` = `FRAME_EDGES` (16) and `cfgSleep`=1 moves the idle block to `powerState` 2 with `sleepEn` high. The code 3 never appears.
- R8: In deep power-down, start edges do not start conversions. A last-edge strobe with `cfgSleep`=0 that is not preceded by a start edge leaves the block in state 2.
- R9: After a start edge in deep power-down, the last-edge strobe with `cfgSleep`=0 returns the block to state 0. For the next `WAKE_CYCLES` cycles, start edges are ignored.
- R10: `resultValid` is 0 while `busyN` is low. After the first conversion that follows an exit from deep power-down it stays 0. After any other conversion it becomes 1.
- R11: After reset, `busyN`=1, `powerState`=0, `napEn`=0, `sleepEn`=0 and `resultValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| convSt | input | 1 | Conversion start, rising edge acts |
| sckFall | input | 1 | One-cycle strobe per falling serial-clock edge |
| sckIndex | input | IDX_W | 1-based index of that edge within the frame |
| cfgNap | input | 1 | Latched light power-down request |
| cfgSleep | input | 1 | Latched deep power-down request |
| busyN | output | 1 | Low while a conversion runs |
| powerState | output | 2 | 0 ON, 1 light power-down, 2 deep power-down |
| napEn | output | 1 | Light power-down enable |
| sleepEn | output | 1 | Deep power-down enable |
| resultValid | output | 1 | Last conversion result is usable |

## Verification
The checker enforces the following on every cycle: the exact busy length, the absence of any conversion during deep power-down, entry into light power-down at the end of a conversion, a legal state code, and a cleared valid flag while busy. These properties also catch a restart that stretches the busy period. Other behaviour depends on what happens in sequence, and only the directed scenarios can show it. This covers the arming rule for the deep-power-down exit, start edges being ignored during the settling window, the stale flag on the first result after wake-up, and the exact serial edge on which each transition happens.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    PWR_ON    = 2'd0,
    PWR_NAP   = 2'd1,
    PWR_SLEEP = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic startConv;
    logic startWake;
  } seq_strobe_t;
endpackage

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int CONV_CYCLES = 800,
  parameter int WAKE_CYCLES = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        convSt,
  input  seq_strobe_t strobe,
  output logic        convRise,
  output logic        converting,
  output logic        convDone,
  output logic        waking
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic          convPrev;
  logic [CW-1:0] convCnt;

  always_ff @(posedge clk) begin
    if (!rstN) convPrev <= 1'b1;
    else       convPrev <= convSt;
  end

  assign convRise = convSt && !convPrev;
  assign convDone = converting && (convCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      converting <= 1'b0;
      convCnt    <= '0;
    end else if (strobe.startConv) begin
      converting <= 1'b1;
      convCnt    <= CW'(CONV_CYCLES - 1);
    end else if (convDone) begin
      converting <= 1'b0;
    end else if (converting) begin
      convCnt <= convCnt - 1'b1;
    end
  end

  generate
    if (WAKE_CYCLES > 0) begin : g_wake
      localparam int WW = $clog2(WAKE_CYCLES + 1);
      logic [WW-1:0] wakeCnt;
      always_ff @(posedge clk) begin
        if (!rstN)                 wakeCnt <= '0;
        else if (strobe.startWake) wakeCnt <= WW'(WAKE_CYCLES);
        else if (wakeCnt != '0)    wakeCnt <= wakeCnt - 1'b1;
      end
      assign waking = (wakeCnt != '0);
    end else begin : g_nowake
      assign waking = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/adcseq_control.sv
module adcseq_control
  import adcseq_pkg::*;
#(
  parameter int IDX_W         = 5,
  parameter int FRAME_EDGES   = 16,
  parameter int NAP_EXIT_EDGE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convRise,
  input  logic             converting,
  input  logic             convDone,
  input  logic             waking,
  input  logic             sckFall,
  input  logic [IDX_W-1:0] sckIndex,
  input  logic             cfgNap,
  input  logic             cfgSleep,
  output seq_strobe_t      strobe,
  output pwr_state_e       pwrState,
  output logic             resultValid
);
  logic sckLast, sckNapExit, wakeArmed, staleNext;

  assign sckLast    = sckFall && (sckIndex == IDX_W'(FRAME_EDGES));
  assign sckNapExit = sckFall && (sckIndex == IDX_W'(NAP_EXIT_EDGE));

  assign strobe.startConv = convRise && !converting && !waking && (pwrState == PWR_ON);
  assign strobe.startWake = (pwrState == PWR_SLEEP) && wakeArmed && sckLast && !cfgSleep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrState  <= PWR_ON;
      wakeArmed <= 1'b0;
    end else begin
      case (pwrState)
        PWR_ON: begin
          wakeArmed <= 1'b0;
          if (convDone && cfgNap && !cfgSleep)      pwrState <= PWR_NAP;
          else if (sckLast && cfgSleep && !converting) pwrState <= PWR_SLEEP;
        end
        PWR_NAP: begin
          if (sckLast && cfgSleep) pwrState <= PWR_SLEEP;
          else if (sckNapExit)     pwrState <= PWR_ON;
        end
        PWR_SLEEP: begin
          if (strobe.startWake) begin
            pwrState  <= PWR_ON;
            wakeArmed <= 1'b0;
          end else if (convRise) begin
            wakeArmed <= 1'b1;
          end
        end
        default: pwrState <= PWR_ON;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      staleNext   <= 1'b0;
    end else begin
      if (strobe.startWake) staleNext <= 1'b1;
      if (strobe.startConv) begin
        resultValid <= 1'b0;
      end else if (convDone) begin
        resultValid <= !staleNext;
        staleNext   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_power_sequencer.sv
module adc_power_sequencer
  import adcseq_pkg::*;
#(
  parameter int CONV_CYCLES   = 800,
  parameter int WAKE_CYCLES   = 2000,
  parameter int IDX_W         = 5,
  parameter int FRAME_EDGES   = 16,
  parameter int NAP_EXIT_EDGE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convSt,
  input  logic             sckFall,
  input  logic [IDX_W-1:0] sckIndex,
  input  logic             cfgNap,
  input  logic             cfgSleep,
  output logic             busyN,
  output logic [1:0]       powerState,
  output logic             napEn,
  output logic             sleepEn,
  output logic             resultValid
);
  seq_strobe_t strobe;
  pwr_state_e  pwrState;
  logic        convRise, converting, convDone, waking;

  adcseq_datapath #(
    .CONV_CYCLES(CONV_CYCLES),
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .convSt(convSt), .strobe(strobe),
    .convRise(convRise), .converting(converting),
    .convDone(convDone), .waking(waking)
  );

  adcseq_control #(
    .IDX_W(IDX_W),
    .FRAME_EDGES(FRAME_EDGES),
    .NAP_EXIT_EDGE(NAP_EXIT_EDGE)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .convRise(convRise), .converting(converting),
    .convDone(convDone), .waking(waking), .sckFall(sckFall),
    .sckIndex(sckIndex), .cfgNap(cfgNap), .cfgSleep(cfgSleep),
    .strobe(strobe), .pwrState(pwrState), .resultValid(resultValid)
  );

  assign busyN      = !converting;
  assign powerState = pwrState;
  assign napEn      = (pwrState == PWR_NAP);
  assign sleepEn    = (pwrState == PWR_SLEEP);
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
  parameter int CONV_CYCLES = 800
) (
  input logic       clk,
  input logic       rstN,
  input logic       busyN,
  input logic [1:0] powerState,
  input logic       napEn,
  input logic       sleepEn,
  input logic       cfgNap,
  input logic       cfgSleep,
  input logic       resultValid
);
  int lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)       lowCnt <= 0;
    else if (!busyN) lowCnt <= lowCnt + 1;
    else             lowCnt <= 0;
  end

  // R2 and R3: each busy period lasts exactly CONV_CYCLES cycles
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> (lowCnt == CONV_CYCLES));

  // R8: no conversion runs in deep power-down
  p_sleep_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleepEn |-> busyN);

  // R5: light power-down starts as the conversion ends
  p_nap_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busyN) && $past(cfgNap) && !$past(cfgSleep)) |-> napEn);

  // R7: only legal codes, enables never both high
  p_state_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    (powerState != 2'd3) && $onehot0({napEn, sleepEn}));

  // R10: valid flag is cleared while busy
  p_valid_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busyN |-> !resultValid);
endmodule

bind adc_power_sequencer adcseq_checker #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .busyN(busyN), .powerState(powerState),
  .napEn(napEn), .sleepEn(sleepEn), .cfgNap(cfgNap), .cfgSleep(cfgSleep),
  .resultValid(resultValid)
);

// File: tb/adc_power_sequencer_test.sv
module adc_power_sequencer_test;
  localparam int CONV = 20;
  localparam int WAKE = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convSt = 1'b0;
  logic       sckFall = 1'b0;
  logic [4:0] sckIndex = '0;
  logic       cfgNap = 1'b0;
  logic       cfgSleep = 1'b0;
  logic       busyN, napEn, sleepEn, resultValid;
  logic [1:0] powerState;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = !clk;

  adc_power_sequencer #(
    .CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE), .IDX_W(5),
    .FRAME_EDGES(16), .NAP_EXIT_EDGE(2)
  ) uut (
    .clk(clk), .rstN(rstN), .convSt(convSt), .sckFall(sckFall),
    .sckIndex(sckIndex), .cfgNap(cfgNap), .cfgSleep(cfgSleep),
    .busyN(busyN), .powerState(powerState), .napEn(napEn),
    .sleepEn(sleepEn), .resultValid(resultValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse convSt and count busy-low cycles; glitchAt>0 adds a restart pulse
  task automatic runConv(output int len, input int glitchAt);
    @(negedge clk) convSt = 1'b1;
    len = 0;
    @(negedge clk) convSt = 1'b0;
    while (!busyN && len < 1000) begin
      len++;
      if (glitchAt > 0 && len == glitchAt) convSt = 1'b1;
      if (glitchAt > 0 && len == glitchAt + 1) convSt = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulseOnly(input string req);
    @(negedge clk) convSt = 1'b1;
    @(negedge clk) convSt = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(req, busyN, 1);
      @(negedge clk);
    end
  endtask

  task automatic sckPulse(input int idx);
    @(negedge clk);
    sckIndex = 5'(idx);
    sckFall  = 1'b1;
    @(negedge clk) sckFall = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R11 busyN", busyN, 1);
    chk("R11 state", powerState, 0);
    chk("R11 napEn", napEn, 0);
    chk("R11 sleepEn", sleepEn, 0);
    chk("R11 valid", resultValid, 0);
  endtask

  task automatic testBasic();
    int len;
    @(negedge clk) convSt = 1'b1;
    @(negedge clk) convSt = 1'b0;
    chk("R1 busy after edge", busyN, 0);
    chk("R10 valid low while busy", resultValid, 0);
    len = 1;
    @(negedge clk);
    while (!busyN && len < 1000) begin len++; @(negedge clk); end
    chk("R2 busy length", len, CONV);
    chk("R10 valid after normal conversion", resultValid, 1);
    chk("R5 no nap when bit clear", powerState, 0);
  endtask

  task automatic testRestart();
    int len;
    runConv(len, 6);
    chk("R3 length with restart", len, CONV);
    for (int i = 0; i < 5; i++) begin
      chk("R3 no second conversion", busyN, 1);
      @(negedge clk);
    end
  endtask

  task automatic testLevel();
    int len;
    @(negedge clk) convSt = 1'b1;
    idle(CONV + 5);
    chk("R4 level high no restart", busyN, 1);
    @(negedge clk) convSt = 1'b0;
    runConv(len, 0);
    chk("R2 length after level test", len, CONV);
  endtask

  task automatic testNap();
    int len;
    cfgNap = 1'b1; cfgSleep = 1'b0;
    runConv(len, 0);
    chk("R5 nap entered", powerState, 1);
    chk("R5 napEn", napEn, 1);
    pulseOnly("R5 start ignored in nap");
    sckPulse(1);
    chk("R6 still nap after edge 1", powerState, 1);
    sckPulse(2);
    chk("R6 on after edge 2", powerState, 0);
    cfgNap = 1'b0;
    for (int i = 3; i <= 16; i++) sckPulse(i);
    chk("R6 stays on", powerState, 0);
  endtask

  task automatic testSleep();
    int len;
    cfgNap = 1'b1; cfgSleep = 1'b1;
    runConv(len, 0);
    chk("R7 sleep beats nap at end", powerState, 0);
    for (int i = 1; i <= 15; i++) sckPulse(i);
    chk("R7 on before edge 16", powerState, 0);
    sckPulse(16);
    chk("R7 sleep at edge 16", powerState, 2);
    chk("R7 sleepEn", sleepEn, 1);
    cfgNap = 1'b0; cfgSleep = 1'b0;
    for (int i = 1; i <= 16; i++) sckPulse(i);
    chk("R8 unarmed frame keeps sleep", powerState, 2);
    pulseOnly("R8 no conversion in sleep");
    chk("R8 still sleep after start", powerState, 2);
    for (int i = 1; i <= 15; i++) sckPulse(i);
    chk("R9 sleep until edge 16", powerState, 2);
    sckPulse(16);
    chk("R9 on after wake frame", powerState, 0);
    pulseOnly("R9 start ignored while settling");
    idle(WAKE + 4);
    runConv(len, 0);
    chk("R9 conversion after settling", len, CONV);
    chk("R10 first result after wake stale", resultValid, 0);
    runConv(len, 0);
    chk("R10 second result valid", resultValid, 1);
  endtask

  initial begin
    idle(4);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testBasic();
    testRestart();
    testLevel();
    testNap();
    testSleep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule